// File: doc/BRIEF.md
# Multi-Port Cell Transmit Slave

This block is the physical-layer side of a shared cell bus that carries fixed-length ATM cells toward a link-layer master. Up to 31 per-port cell queues sit behind it. The master polls a port by driving a 5-bit address while the active-low enable is high. The block answers one cycle later with a cell-available indication, taken from the per-port flag that says at least one complete cell is queued.

The same address, sampled while enable is high and no cell is in flight, selects the port. On every cycle in which the master then holds enable low, the block pulls one word from the selected queue, using a ready/valid handshake toward the queue. It presents that word on the bus with a start-of-cell marker on the first word and odd parity over the data. When the last word of the cell has gone out, the port is released.

Parameters select an 8-bit or 16-bit bus and a 52-byte or 54-byte cell. A single-port build removes the address decode altogether.

Top module: `utx_mphy_slave`

## Requirements
- R1: `clav` is a registered result. After a rising edge at which `poll_addr` held the number p of an existing port, `clav` equals `cell_flag[p]` as sampled at that edge.
- R2: After an edge at which `poll_addr` was 31 (the null address) or any value of `NUM_PORTS` or above, `clav` is 0.
- R3: At an edge where `enb_n` is 1 and no cell is in progress, a valid port address selects that port and replaces any earlier selection. An invalid address (31, or `NUM_PORTS` and above) leaves no port selected, and a later low `enb_n` then reads nothing.
- R4: While `enb_n` is 0, a port is selected and that port's `q_valid` is 1, `q_rd` is one-hot on the selected port. The word read appears on `tx_data` after that rising edge.
- R5: `tx_soc` is 1 only while `tx_data` carries the first word of a cell.
- R6: `tx_par` is odd parity: `tx_data` together with `tx_par` always holds an odd number of ones. The reset value is data 0 with `tx_par` 1.
- R7: While `enb_n` is 1 in the middle of a cell, no queue is read. `tx_data` holds its value, `tx_soc` stays 0, and an address on `poll_addr` does not change the selection.
- R8: A cell ends after 52/W·8 or 54/W·8 words (27 with the default 16-bit, 54-byte setting). The port is then released, and a further low `enb_n` reads nothing.
- R9: While the selected queue has `q_valid` 0, no read takes place and the cell word count does not advance.
- R10: With `SINGLE` set, `clav` follows `cell_flag[0]` one cycle later whatever the address, and port 0 is always the selected port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_addr | input | 5 | Polling and selection address |
| enb_n | input | 1 | Active-low transfer enable from the master |
| clav | output | 1 | Cell available for the polled address |
| tx_data | output | W (8 or 16) | Cell word toward the master |
| tx_soc | output | 1 | Start-of-cell marker |
| tx_par | output | 1 | Odd parity over `tx_data` |
| q_data | input | NUM_PORTS*W | Head word of each queue, port p at bits [p*W +: W] |
| q_valid | input | NUM_PORTS | Head word valid per queue |
| q_rd | output | NUM_PORTS | Read strobe (ready) per queue |
| cell_flag | input | NUM_PORTS | At least one complete cell queued per port |

## Verification
`clav`, `tx_data`, `tx_soc` and `tx_par` are due one rising edge after the cycle that causes them. `q_rd` is combinational in the same cycle as the low `enb_n` that asks for it. The bench drives all inputs on the falling edge. It checks `q_rd` a moment after driving, and checks the registered outputs at the next falling edge. The transfer driver pushes each expected word into a scoreboard queue and marks the cycle as a transfer cycle. A monitor pops and compares only on the falling edge after such a cycle, so pause and stall cycles are checked separately for held outputs.

// File: rtl/utx_pkg.sv
package utx_pkg;
  localparam logic [4:0] NULL_ADDR = 5'd31;

  function automatic int cell_words(input int wide16, input int cell54);
    int bytes;
    bytes = (cell54 != 0) ? 54 : 52;
    return (wide16 != 0) ? bytes / 2 : bytes;
  endfunction
endpackage

// File: rtl/utx_rst_sync.sv
module utx_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/utx_poll_resp.sv
module utx_poll_resp #(
  parameter int NUM_PORTS = 8,
  parameter bit SINGLE    = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [4:0]           poll_addr,
  input  logic [NUM_PORTS-1:0] cell_flag,
  output logic                 clav
);
  logic clav_nxt;

  generate
    if (SINGLE) begin : g_single
      always_comb clav_nxt = cell_flag[0];
    end else begin : g_multi
      always_comb begin
        clav_nxt = 1'b0;
        for (int i = 0; i < NUM_PORTS; i++) begin
          if (poll_addr == 5'(i) && poll_addr != utx_pkg::NULL_ADDR)
            clav_nxt = cell_flag[i];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clav <= 1'b0;
    else        clav <= clav_nxt;
  end
endmodule

// File: rtl/utx_port_sel.sv
module utx_port_sel #(
  parameter int NUM_PORTS = 8,
  parameter int W         = 16,
  parameter bit SINGLE    = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             poll_addr,
  input  logic                   enb_n,
  input  logic                   cell_idle,
  input  logic                   cell_done,
  input  logic [NUM_PORTS*W-1:0] q_data,
  input  logic [NUM_PORTS-1:0]   q_valid,
  output logic [4:0]             sel_port,
  output logic                   sel_live,
  output logic [W-1:0]           head_word,
  output logic                   head_valid
);
  logic [4:0] port_nxt;
  logic       live_nxt;
  logic       sel_en;
  logic       addr_hit;

  always_comb begin
    addr_hit = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (poll_addr == 5'(i) && poll_addr != utx_pkg::NULL_ADDR) addr_hit = 1'b1;
  end

  assign sel_en = (enb_n && cell_idle) || cell_done;

  generate
    if (SINGLE) begin : g_single
      always_comb begin
        port_nxt = 5'd0;
        live_nxt = 1'b1;
      end
    end else begin : g_multi
      always_comb begin
        port_nxt = sel_port;
        live_nxt = sel_live;
        if (cell_done) begin
          live_nxt = 1'b0;
        end else if (enb_n && cell_idle) begin
          live_nxt = addr_hit;
          port_nxt = addr_hit ? poll_addr : 5'd0;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_port <= 5'd0;
      sel_live <= 1'b0;
    end else if (sel_en) begin
      sel_port <= port_nxt;
      sel_live <= live_nxt;
    end
  end

  always_comb begin
    head_word  = '0;
    head_valid = 1'b0;
    for (int i = 0; i < NUM_PORTS; i++) begin
      if (sel_port == 5'(i)) begin
        head_word  = q_data[i*W +: W];
        head_valid = q_valid[i];
      end
    end
  end
endmodule

// File: rtl/utx_cell_seq.sv
module utx_cell_seq #(
  parameter int W     = 16,
  parameter int WORDS = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer,
  input  logic [W-1:0] word_in,
  output logic         cell_idle,
  output logic         cell_done,
  output logic [W-1:0] tx_data,
  output logic         tx_soc,
  output logic         tx_par
);
  localparam int CW = $clog2(WORDS);

  logic [CW-1:0] cnt_q, cnt_nxt;
  logic [W-1:0]  data_nxt;
  logic          soc_nxt, par_nxt;
  logic          last_word;

  assign last_word = (cnt_q == CW'(WORDS - 1));
  assign cell_idle = (cnt_q == '0);
  assign cell_done = xfer && last_word;

  always_comb begin
    cnt_nxt  = cnt_q;
    data_nxt = tx_data;
    par_nxt  = tx_par;
    soc_nxt  = 1'b0;
    if (xfer) begin
      cnt_nxt  = last_word ? '0 : cnt_q + 1'b1;
      data_nxt = word_in;
      par_nxt  = ~(^word_in);
      soc_nxt  = cell_idle;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      tx_data <= '0;
      tx_soc  <= 1'b0;
      tx_par  <= 1'b1;
    end else begin
      cnt_q   <= cnt_nxt;
      tx_data <= data_nxt;
      tx_soc  <= soc_nxt;
      tx_par  <= par_nxt;
    end
  end
endmodule

// File: rtl/utx_mphy_slave.sv
module utx_mphy_slave #(
  parameter int NUM_PORTS = 8,
  parameter bit WIDE16    = 1'b1,
  parameter bit CELL54    = 1'b1,
  parameter bit SINGLE    = 1'b0,
  localparam int W        = 8 + 8 * int'(WIDE16),
  localparam int WORDS    = utx_pkg::cell_words(int'(WIDE16), int'(CELL54))
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [4:0]             poll_addr,
  input  logic                   enb_n,
  output logic                   clav,
  output logic [W-1:0]           tx_data,
  output logic                   tx_soc,
  output logic                   tx_par,
  input  logic [NUM_PORTS*W-1:0] q_data,
  input  logic [NUM_PORTS-1:0]   q_valid,
  output logic [NUM_PORTS-1:0]   q_rd,
  input  logic [NUM_PORTS-1:0]   cell_flag
);
  logic         rst_n_s;
  logic [4:0]   sel_port;
  logic         sel_live;
  logic [W-1:0] head_word;
  logic         head_valid;
  logic         cell_idle, cell_done;
  logic         xfer;

  utx_rst_sync rst_i (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  utx_poll_resp #(.NUM_PORTS(NUM_PORTS), .SINGLE(SINGLE)) poll_i (
    .clk(clk), .rst_n(rst_n_s), .poll_addr(poll_addr),
    .cell_flag(cell_flag), .clav(clav)
  );

  utx_port_sel #(.NUM_PORTS(NUM_PORTS), .W(W), .SINGLE(SINGLE)) sel_i (
    .clk(clk), .rst_n(rst_n_s), .poll_addr(poll_addr), .enb_n(enb_n),
    .cell_idle(cell_idle), .cell_done(cell_done), .q_data(q_data),
    .q_valid(q_valid), .sel_port(sel_port), .sel_live(sel_live),
    .head_word(head_word), .head_valid(head_valid)
  );

  assign xfer = !enb_n && sel_live && head_valid;

  utx_cell_seq #(.W(W), .WORDS(WORDS)) seq_i (
    .clk(clk), .rst_n(rst_n_s), .xfer(xfer), .word_in(head_word),
    .cell_idle(cell_idle), .cell_done(cell_done), .tx_data(tx_data),
    .tx_soc(tx_soc), .tx_par(tx_par)
  );

  always_comb begin
    q_rd = '0;
    for (int i = 0; i < NUM_PORTS; i++)
      if (xfer && sel_port == 5'(i)) q_rd[i] = 1'b1;
  end
endmodule

// File: rtl/utx_mphy_slave_chk.sv
module utx_mphy_slave_chk #(
  parameter int NUM_PORTS = 8,
  parameter int W         = 16,
  parameter bit SINGLE    = 1'b0
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [4:0]           poll_addr,
  input logic                 enb_n,
  input logic                 clav,
  input logic [W-1:0]         tx_data,
  input logic                 tx_soc,
  input logic                 tx_par,
  input logic [NUM_PORTS-1:0] q_rd
);
  generate
    if (!SINGLE) begin : g_null
      a_r2_null_clav: assert property (@(posedge clk) disable iff (!rst_n)
        (poll_addr == 5'd31) |=> !clav);
    end
  endgenerate

  a_r4_rd_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(q_rd));

  a_r7_no_rd_enb_high: assert property (@(posedge clk) disable iff (!rst_n)
    enb_n |-> (q_rd == '0));

  a_r6_odd_parity: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_rd) |=> (^{tx_data, tx_par}) == 1'b1);

  a_r5_soc_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(|q_rd) |=> !tx_soc);

  a_r7_hold_without_read: assert property (@(posedge clk) disable iff (!rst_n)
    !(|q_rd) |=> $stable(tx_data));
endmodule

bind utx_mphy_slave utx_mphy_slave_chk #(
  .NUM_PORTS(NUM_PORTS), .W(W), .SINGLE(SINGLE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .enb_n(enb_n),
  .clav(clav), .tx_data(tx_data), .tx_soc(tx_soc), .tx_par(tx_par),
  .q_rd(q_rd)
);

// File: tb/utx_mphy_slave_tb_top.sv
module utx_mphy_slave_tb_top;
  localparam int NP    = 8;
  localparam int W     = 16;
  localparam int WORDS = 27;

  logic            clk;
  logic            rst_n;
  logic [4:0]      poll_addr;
  logic            enb_n;
  logic            clav;
  logic [W-1:0]    tx_data;
  logic            tx_soc, tx_par;
  logic [NP*W-1:0] q_data;
  logic [NP-1:0]   q_valid, q_rd, cell_flag;

  logic            s_clav, s_soc, s_par, s_rd;
  logic [W-1:0]    s_data;
  logic            s_flag;

  int errors = 0;
  int checks = 0;
  bit finished = 0;
  int ptr [NP];
  logic [W+1:0] exp_q [$];
  logic [W-1:0] last_data;
  bit pend, pend_d;

  utx_mphy_slave #(.NUM_PORTS(NP)) dut_i (
    .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .enb_n(enb_n),
    .clav(clav), .tx_data(tx_data), .tx_soc(tx_soc), .tx_par(tx_par),
    .q_data(q_data), .q_valid(q_valid), .q_rd(q_rd), .cell_flag(cell_flag)
  );

  utx_mphy_slave #(.NUM_PORTS(1), .SINGLE(1'b1)) dut_single_i (
    .clk(clk), .rst_n(rst_n), .poll_addr(poll_addr), .enb_n(1'b1),
    .clav(s_clav), .tx_data(s_data), .tx_soc(s_soc), .tx_par(s_par),
    .q_data(16'h0), .q_valid(1'b0), .q_rd(s_rd), .cell_flag(s_flag)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [W-1:0] gen_word(input int p, input int idx);
    return {4'(p), 4'(idx * 3), 8'(idx * 37 + p)};
  endfunction

  always_comb
    for (int p = 0; p < NP; p++) q_data[p*W +: W] = gen_word(p, ptr[p]);

  always @(posedge clk) begin
    for (int p = 0; p < NP; p++) if (q_rd[p]) ptr[p] <= ptr[p] + 1;
    pend_d <= pend;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (pend_d && rst_n) begin
      logic [W+1:0] e;
      e = exp_q.pop_front();
      chk(tx_data == e[W-1:0], "R4 data", tx_data, e[W-1:0]);
      chk(tx_soc == e[W+1], "R5 soc", tx_soc, e[W+1]);
      chk(tx_par == e[W], "R6 parity", tx_par, e[W]);
    end
  end

  task automatic poll(input logic [4:0] a, input bit exp_clav, input string req);
    poll_addr = a; enb_n = 1'b1; pend = 1'b0;
    @(negedge clk);
    chk(clav == exp_clav, req, clav, exp_clav);
  endtask

  task automatic send_cell(input int p, input int pause_at, input int stall_at);
    int base;
    base = ptr[p];
    for (int k = 0; k < WORDS; k++) begin
      if (k == pause_at) begin
        enb_n = 1'b1; poll_addr = 5'((p + 1) % NP); pend = 1'b0;
        #1 chk(q_rd == '0, "R7 no read on pause", q_rd, 0);
        @(negedge clk);
        chk(tx_data == last_data, "R7 data held", tx_data, last_data);
        chk(tx_soc == 1'b0, "R7 soc low", tx_soc, 0);
      end
      if (k == stall_at) begin
        enb_n = 1'b0; q_valid[p] = 1'b0; pend = 1'b0;
        #1 chk(q_rd == '0, "R9 no read when invalid", q_rd, 0);
        @(negedge clk);
        chk(tx_data == last_data, "R9 data held", tx_data, last_data);
        q_valid[p] = 1'b1;
      end
      enb_n = 1'b0; pend = 1'b1;
      last_data = gen_word(p, base + k);
      exp_q.push_back({(k == 0), ~(^last_data), last_data});
      #1 chk(q_rd == NP'(1) << p, "R4 read strobe", q_rd, NP'(1) << p);
      @(negedge clk);
    end
    enb_n = 1'b0; pend = 1'b0;
    #1 chk(q_rd == '0, "R8 released after last word", q_rd, 0);
    @(negedge clk);
    chk(tx_data == last_data, "R8 no extra word", tx_data, last_data);
    enb_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) ptr[p] = 0;
    rst_n = 1'b0; poll_addr = 5'd31; enb_n = 1'b1; pend = 1'b0;
    q_valid = '1; cell_flag = '0; s_flag = 1'b0; last_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // reset state
    chk(clav == 1'b0, "R1 reset clav", clav, 0);
    chk(tx_soc == 1'b0, "R5 reset soc", tx_soc, 0);
    chk(tx_data == '0 && tx_par == 1'b1, "R6 reset parity", {tx_data, tx_par}, 1);
    chk(q_rd == '0, "R4 reset no read", q_rd, 0);

    // R1 polling each port
    cell_flag = 8'b1010_0110;
    for (int p = 0; p < NP; p++) poll(5'(p), cell_flag[p], "R1 polled flag");
    cell_flag = '1;
    poll(5'd31, 1'b0, "R2 null address");
    poll(5'd8, 1'b0, "R2 address beyond ports");
    poll(5'd4, 1'b1, "R1 flag set");

    // R3 deselection by null address
    poll(5'd3, 1'b1, "R3 select 3");
    poll(5'd31, 1'b0, "R3 deselect");
    enb_n = 1'b0;
    #1 chk(q_rd == '0, "R3 no port after null", q_rd, 0);
    @(negedge clk);

    // plain cell on port 2
    poll(5'd2, 1'b1, "R3 select 2");
    send_cell(2, -1, -1);

    // later selection wins
    poll(5'd6, 1'b1, "R3 select 6");
    poll(5'd1, 1'b1, "R3 reselect 1");
    send_cell(1, -1, -1);

    // pause and stall on port 5
    poll(5'd5, 1'b1, "R3 select 5");
    send_cell(5, 10, 20);

    // back-to-back second cell on port 5
    poll(5'd5, 1'b1, "R3 select 5 again");
    send_cell(5, 3, 4);

    // R10 single build ignores address
    s_flag = 1'b1;
    poll(5'd31, 1'b0, "R2 null multi");
    chk(s_clav == 1'b1, "R10 single clav null addr", s_clav, 1);
    s_flag = 1'b0;
    poll(5'd7, 1'b1, "R1 port 7");
    chk(s_clav == 1'b0, "R10 single clav follows flag", s_clav, 0);

    @(negedge clk);
    chk(exp_q.size() == 0, "R4 scoreboard drained", exp_q.size(), 0);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule